// File: doc/BRIEF.md
# Serial Channel Baud Tick Generator

This block produces the timing strobes for one asynchronous serial channel. It runs a chain of three counters from the system clock. The first is a fixed prescaler that divides by 10 or by 30. The second divides by a selectable power of two, from 1 to 64. Its output is the sampling strobe. The third counts sampling strobes and fires once per bit time, after 16 or 64 of them. Every output is a single-cycle enable in the system clock domain, so the serial engine that uses them needs no second clock.

A speed code of all ones bypasses the internal chain. In that mode, rising edges on an external clock pin become the sampling strobes, after a two-flop synchronizer. The bit-time counter then divides them by 16, by 64, or, when the external ×1 bit is set, by 1. The same 8-bit control register also holds the parity-sense bit, which goes straight out to the serial engine.

Any write to the control register clears all three counters. The new setting therefore always starts from a full period.

Top module: `baud_tick_gen`

## Requirements
- R1: Control bit 5 selects the prescale: 0 divides the system clock by 10, 1 divides it by 30.
- R2: Control bits 2:0 (speed code s, 0 to 6) divide the prescaler output by 2^s. `sample_tick` pulses once every prescale × 2^s system cycles.
- R3: Control bit 3 sets the bit-time ratio: 0 gives one `bit_tick` per 16 `sample_tick` pulses, and 1 gives one per 64.
- R4: With speed code 7, each rising edge of `ext_clk_in` gives one `sample_tick`. The pulse is visible two system cycles after the first clock edge that samples the input high, and the internal chain is silent. With any other code, `ext_clk_in` has no effect on the outputs.
- R5: Control bit 6 (external ×1), when set with speed code 7, makes every `sample_tick` also a `bit_tick`. With codes 0 to 6 it has no effect.
- R6: `parity_odd` equals control bit 4 (0 means even, 1 means odd) and changes only on a write.
- R7: After reset the control register reads 8'h07 (external source, ratio 16, even parity, ÷10, ×1 off). `parity_odd` is 0 and neither tick is asserted.
- R8: A write clears every counter. With an internal code, the first `sample_tick` comes exactly prescale × 2^s cycles after the write edge. The first `bit_tick` comes exactly prescale × 2^s × ratio cycles after it.
- R9: `cfg_rdata` returns all 8 written bits, including spare bit 7, from the cycle after the write.
- R10: Each tick is one cycle wide, and `bit_tick` is only ever asserted together with `sample_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| ext_clk_in | input | 1 | External sampling clock, asynchronous |
| sample_tick | output | 1 | Sampling-clock enable pulse |
| bit_tick | output | 1 | Bit-rate enable pulse |
| parity_odd | output | 1 | Parity sense: 1 odd, 0 even |

## Verification
Some properties are checked on every cycle. The ticks are one cycle wide and `bit_tick` only appears with `sample_tick`. The readback equals the last write and the parity output only moves on a write. The prescale count stays inside its selected range, the internal prescaler stays silent in external mode, and no tick follows a write in an internal mode.

The exact periods can only be shown by the bench's scenarios. These cover every prescale and speed code combination, and both bit-time ratios. They also cover the restart from a write, the synchronizer latency of external edges, and the fact that the ×1 bit and the external pin do nothing in internal modes.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int SPEED_W = 3;
  localparam logic [SPEED_W-1:0] SPEED_EXT = '1;

  // Control register image, bit 7 down to bit 0.
  typedef struct packed {
    logic                spare;     // 7: stored and read back only
    logic                ext_x1;    // 6: external clock taken undivided
    logic                pre_slow;  // 5: prescale 30 instead of 10
    logic                par_odd;   // 4: odd parity sense
    logic                ratio_hi;  // 3: 64 samples per bit instead of 16
    logic [SPEED_W-1:0]  speed;     // 2:0: power-of-two code, all ones = external
  } baud_cfg_t;

  localparam baud_cfg_t CFG_RESET = '{spare: 1'b0, ext_x1: 1'b0, pre_slow: 1'b0,
                                      par_odd: 1'b0, ratio_hi: 1'b0, speed: SPEED_EXT};

  function automatic logic is_ext(input baud_cfg_t c);
    return c.speed == SPEED_EXT;
  endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [7:0] wdata,
  output baud_cfg_t cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= CFG_RESET;
    else if (wr) cfg <= baud_cfg_t'(wdata);
  end

endmodule

// File: rtl/baud_ext_sync.sv
module baud_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], din};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/baud_stage_ctr.sv
module baud_stage_ctr #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [CW-1:0] last,
  output logic          wrap,
  output logic [CW-1:0] cnt
);

  assign wrap = step && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (restart) cnt <= '0;
    else if (step) cnt <= wrap ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int PRE_LO      = 10,
  parameter int PRE_HI      = 30,
  parameter int RATIO_LO    = 16,
  parameter int RATIO_HI    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       ext_clk_in,
  output logic       sample_tick,
  output logic       bit_tick,
  output logic       parity_odd
);

  localparam int PRE_W = $clog2(PRE_HI);
  localparam int POW_W = (1 << SPEED_W) - 2;
  localparam int RAT_W = $clog2(RATIO_HI);

  function automatic logic [PRE_W-1:0] pre_last_f(input logic slow);
    return slow ? PRE_W'(PRE_HI - 1) : PRE_W'(PRE_LO - 1);
  endfunction

  function automatic logic [POW_W-1:0] pow_last_f(input logic [SPEED_W-1:0] s);
    logic [POW_W-1:0] v;
    v = '0;
    for (int i = 0; i < POW_W; i++) if (i < int'(s)) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [RAT_W-1:0] ratio_last_f(input baud_cfg_t c);
    if (is_ext(c) && c.ext_x1) return '0;
    return c.ratio_hi ? RAT_W'(RATIO_HI - 1) : RAT_W'(RATIO_LO - 1);
  endfunction

  baud_cfg_t cfg;

  baud_cfg_reg u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (cfg_wr),
    .wdata(cfg_wdata),
    .cfg  (cfg)
  );

  // Named internal events for the checker.
  logic             ext_mode;
  logic             ext_rise;
  logic [PRE_W-1:0] pre_last;
  logic [PRE_W-1:0] pre_cnt;
  logic             pre_wrap;
  logic [POW_W-1:0] pow_cnt;
  logic             pow_wrap;
  logic [RAT_W-1:0] rat_cnt;
  logic             rat_wrap;

  assign ext_mode = is_ext(cfg);
  assign pre_last = pre_last_f(cfg.pre_slow);

  baud_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_clk_in),
    .rise (ext_rise)
  );

  baud_stage_ctr #(.CW(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(cfg_wr),
    .step   (~ext_mode),
    .last   (pre_last),
    .wrap   (pre_wrap),
    .cnt    (pre_cnt)
  );

  baud_stage_ctr #(.CW(POW_W)) u_pow (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(cfg_wr),
    .step   (pre_wrap),
    .last   (pow_last_f(cfg.speed)),
    .wrap   (pow_wrap),
    .cnt    (pow_cnt)
  );

  assign sample_tick = ext_mode ? (ext_rise & ~cfg_wr) : pow_wrap;

  baud_stage_ctr #(.CW(RAT_W)) u_rat (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(cfg_wr),
    .step   (sample_tick),
    .last   (ratio_last_f(cfg)),
    .wrap   (rat_wrap),
    .cnt    (rat_cnt)
  );

  assign bit_tick   = rat_wrap;
  assign cfg_rdata  = cfg;
  assign parity_odd = cfg.par_odd;

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int PRE_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [7:0]       cfg_wdata,
  input logic [7:0]       cfg_rdata,
  input logic             sample_tick,
  input logic             bit_tick,
  input logic             parity_odd,
  input logic             ext_mode,
  input logic             pre_wrap,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [PRE_W-1:0] pre_last
);

  assert_reset_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_rdata == 8'h07) && !bit_tick && !parity_odd);

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata));

  assert_parity_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(parity_odd));

  assert_single_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  assert_bit_on_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_last);

  assert_ext_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> !pre_wrap);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[2:0] != 3'b111) |=> !sample_tick && !bit_tick);

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.PRE_W(PRE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .sample_tick(sample_tick),
  .bit_tick   (bit_tick),
  .parity_odd (parity_odd),
  .ext_mode   (ext_mode),
  .pre_wrap   (pre_wrap),
  .pre_cnt    (pre_cnt),
  .pre_last   (pre_last)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       ext_clk_in = 1'b0;
  logic       sample_tick;
  logic       bit_tick;
  logic       parity_odd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  int exp_q[$];
  int s_cnt, b_cnt, s_first;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ext_clk_in(ext_clk_in), .sample_tick(sample_tick),
    .bit_tick(bit_tick), .parity_odd(parity_odd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Monitor: pops expected bit-tick stamps and compares.
  always @(negedge clk) begin
    if (mon_en) begin
      if (sample_tick) begin
        s_cnt++;
        if (s_first < 0) s_first = cyc;
      end
      if (bit_tick) begin
        b_cnt++;
        check(sample_tick, "R10 bit_tick without sample_tick", 0, 1);
        if (exp_q.size() == 0) check(1'b0, "R3/R8 unexpected bit_tick at cycle", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, "R3/R8 bit_tick cycle", cyc, e);
        end
      end
    end
  end

  task automatic open_window(input logic [7:0] cfg);
    step();
    cfg_wr = 1'b1;
    cfg_wdata = cfg;
    step();
    cfg_wr = 1'b0;
    exp_q.delete();
    s_cnt = 0;
    b_cnt = 0;
    s_first = -1;
    mon_en = 1'b1;
    check(cfg_rdata == cfg, "R9 readback", cfg_rdata, cfg);
    check(parity_odd == cfg[4], "R6 parity_odd", parity_odd, cfg[4]);
  endtask

  task automatic run_int(input bit pre, input int sel, input bit ratio, input bit x1,
                         input bit par, input bit wiggle);
    logic [7:0] cfg;
    int p, d, r, c0;
    cfg = {1'b0, x1, pre, par, ratio, 3'(sel)};
    p = pre ? 30 : 10;
    d = 1 << sel;
    r = ratio ? 64 : 16;
    c0 = cyc + 1;
    open_window(cfg);
    exp_q.push_back(c0 + p * d * r);
    repeat (p * d * r) begin
      step();
      if (wiggle) ext_clk_in = ~ext_clk_in;
    end
    mon_en = 1'b0;
    ext_clk_in = 1'b0;
    check(s_first == c0 + p * d, "R1/R2/R8 first sample_tick cycle", s_first, c0 + p * d);
    check(s_cnt == r, "R3 sample ticks per bit (R5 x1 ignored, R4 pin ignored)", s_cnt, r);
    check(exp_q.size() == 0, "R8 missing bit_tick", exp_q.size(), 0);
  endtask

  task automatic run_ext(input bit ratio, input bit x1, input int n);
    logic [7:0] cfg;
    int rx, cs;
    cfg = {1'b0, x1, 1'b0, 1'b1, ratio, 3'b111};
    rx = x1 ? 1 : (ratio ? 64 : 16);
    ext_clk_in = 1'b0;
    repeat (4) step();
    open_window(cfg);
    cs = cyc;
    for (int j = 0; j < n; j++) if (j % rx == rx - 1) exp_q.push_back(cs + 6 * j + 2);
    for (int j = 0; j < n; j++) begin
      ext_clk_in = 1'b1;
      repeat (3) step();
      ext_clk_in = 1'b0;
      repeat (3) step();
    end
    mon_en = 1'b0;
    check(s_first == cs + 2, "R4 external edge latency", s_first, cs + 2);
    check(s_cnt == n, "R4 one sample_tick per external edge", s_cnt, n);
    check(b_cnt == n / rx, "R3/R5 bit ticks from external clock", b_cnt, n / rx);
    check(exp_q.size() == 0, "R5 missing bit_tick", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    step();
    // R7: reset state
    check(cfg_rdata == 8'h07, "R7 reset register value", cfg_rdata, 8'h07);
    check(parity_odd == 1'b0, "R7 reset parity", parity_odd, 0);
    repeat (5) begin
      step();
      check(!sample_tick && !bit_tick, "R7 no ticks after reset", sample_tick | bit_tick, 0);
    end
    run_ext(1'b0, 1'b0, 32);
    for (int pre = 0; pre < 2; pre++)
      for (int sel = 0; sel < 7; sel++)
        run_int(pre[0], sel, 1'b0, 1'b0, sel[0], 1'b0);
    for (int pre = 0; pre < 2; pre++)
      for (int sel = 0; sel < 3; sel++)
        run_int(pre[0], sel, 1'b1, 1'b0, 1'b1, 1'b0);
    run_int(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b1);   // R5 and R4 in internal mode
    run_ext(1'b1, 1'b0, 64);
    run_ext(1'b0, 1'b1, 8);
    // R9: spare bit and full image
    step();
    cfg_wr = 1'b1;
    cfg_wdata = 8'hC2;
    step();
    cfg_wr = 1'b0;
    check(cfg_rdata == 8'hC2, "R9 full readback", cfg_rdata, 8'hC2);
    check(parity_odd == 1'b0, "R6 parity even", parity_odd, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R8: actual cycles %0d expected under %0d", cyc, 180000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule